// File: doc/BRIEF.md
# Single-Precision Float to 32-Bit Integer Converter

This block turns a single-precision floating-point operand into a 32-bit integer. Each operation chooses a signed or unsigned result, and it chooses the rounding source. The source is either a fixed truncation toward zero or the rounding mode held in a configuration register. A flush-to-zero control treats denormal inputs as exact zeros. Results that fall outside the destination range are clamped to the nearest end of that range and never wrap. NaN and infinity inputs raise an invalid-operation flag.

Operands enter through a valid/ready handshake. A result leaves two cycles later from a registered output stage, together with three per-operation flags. The same flags are also gathered into a sticky status word. That word keeps its bits until a clear pulse is given. When the output holds a result that the consumer has not taken, the pipeline stalls and input ready drops.

Top module: `f2i_conv`

## Requirements
- R1: When `in_use_cfg` is 0, the result is rounded toward zero, whatever the value of `cfg_rmode`.
- R2: When `in_use_cfg` is 1, `cfg_rmode` selects the rounding: 00 is nearest with ties to even, 01 is toward plus infinity, 10 is toward minus infinity and 11 is toward zero.
- R3: When `cfg_ftz` is 1, a denormal input converts as an exact zero. When it is 0, the denormal converts by its true tiny value under the selected rounding.
- R4: A signed result above 2^31-1 gives 0x7FFFFFFF, and a signed result below -2^31 gives 0x80000000. Both set the saturated flag. An input of exactly -2^31 gives 0x80000000 with no flag.
- R5: An unsigned result below zero after rounding gives 0 and sets the saturated flag. A result above 2^32-1 gives 0xFFFFFFFF and sets the saturated flag. A negative input that rounds to 0 gives 0 without saturation.
- R6: A NaN gives 0 with only the invalid flag set. An infinity gives the range end in its own sign direction and sets both invalid and saturated.
- R7: The inexact flag is set when the discarded fraction is nonzero and the result is neither saturated nor a NaN result.
- R8: The flag layout in `out_flags` and `status` is bit 0 invalid, bit 1 saturated and bit 2 inexact. The status bits accumulate the flags of each delivered result and stay set until `status_clr` is pulsed. If a clear and a new flag fall in the same cycle, the new flag is kept.
- R9: A result appears on the output two clock edges after its input is accepted. `in_ready` is high exactly when the output register is empty or is being read. While `out_ready` is low, the output holds its value.
- R10: After reset, `out_valid` is 0, `status` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Operand accepted on this edge when high |
| in_bits | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1: signed result, 0: unsigned result |
| in_use_cfg | input | 1 | 1: round by cfg_rmode, 0: round toward zero |
| cfg_rmode | input | 2 | Configured rounding mode |
| cfg_ftz | input | 1 | Flush denormal inputs to zero |
| status_clr | input | 1 | Clear the sticky status bits |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result valid |
| out_int | output | 32 | Integer result |
| out_flags | output | 3 | Flags of this result |
| status | output | 3 | Sticky accumulated flags |

## Verification
The flags of a new result can reach the status word in the same cycle that software pulses the clear. The bench accepts an operand that sets a flag and raises `status_clr` on the edge where that result lands. It first makes sure an older, different flag is already set. It then expects the old bit to be gone and the new bit to be present. The bench also sweeps a dense grid of exponents, mantissas, signs, result types and rounding choices, and compares each result against an exact integer model.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int INT_W  = 32;
  localparam int FLG_W  = 3;
  localparam int BIAS   = 127;
  // flag bit positions
  localparam int FL_INV = 0;
  localparam int FL_SAT = 1;
  localparam int FL_INX = 2;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef struct packed {
    logic             neg;
    logic [INT_W-1:0] mag;
    logic             grd;
    logic             stk;
    logic             big;
    logic             nan;
    logic             inf;
    logic             sgn;
    rmode_e           rm;
  } aligned_t;
endpackage

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
(
  input  logic [EXP_W+MAN_W:0] op,
  input  logic                 ftz,
  output logic                 neg,
  output logic [INT_W-1:0]     mag,
  output logic                 grd,
  output logic                 stk,
  output logic                 big,
  output logic                 nan,
  output logic                 inf
);
  localparam int WIDE_W   = INT_W + MAN_W + 2;
  localparam int PT       = MAN_W + 2;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int EXP_BIG  = BIAS + INT_W;
  localparam int EXP_TINY = BIAS - 2;
  localparam int SH_W     = 6;

  logic [EXP_W-1:0]  expf;
  logic [MAN_W-1:0]  frac;
  logic [MAN_W:0]    man;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;

  assign expf = op[EXP_W+MAN_W-1:MAN_W];
  assign frac = op[MAN_W-1:0];
  assign neg  = op[EXP_W+MAN_W];
  assign man  = {1'b1, frac};
  // shift = unbiased exponent + 2, taken modulo 2^SH_W
  assign sh   = expf[SH_W-1:0] - SH_W'(EXP_TINY);

  always_comb begin
    mag  = '0;
    grd  = 1'b0;
    stk  = 1'b0;
    big  = 1'b0;
    nan  = 1'b0;
    inf  = 1'b0;
    wide = '0;
    if (expf == EXP_W'(EXP_MAX)) begin
      nan = (frac != '0);
      inf = (frac == '0);
      big = (frac == '0);
    end else if (expf == '0) begin
      stk = (frac != '0) && !ftz;
    end else if (expf >= EXP_W'(EXP_BIG)) begin
      big = 1'b1;
    end else if (expf < EXP_W'(EXP_TINY)) begin
      stk = 1'b1;
    end else begin
      wide = WIDE_W'(man) << sh;
      mag  = wide[PT+INT_W-1:PT];
      grd  = wide[PT-1];
      stk  = |wide[PT-2:0];
    end
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  aligned_t         a,
  output logic [INT_W-1:0] res,
  output logic [FLG_W-1:0] flags
);
  localparam logic [INT_W:0]   S_MAX_W = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0]   S_MIN_W = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] S_MAX   = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN   = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] U_MAX   = '1;

  logic           inc, lost, sat;
  logic [INT_W:0] rnd;

  assign lost = a.grd | a.stk;

  always_comb begin
    unique case (a.rm)
      RM_NEAR: inc = a.grd & (a.stk | a.mag[0]);
      RM_UP:   inc = !a.neg & lost;
      RM_DOWN: inc = a.neg & lost;
      default: inc = 1'b0;
    endcase
  end

  assign rnd = {1'b0, a.mag} + (INT_W+1)'(inc);

  always_comb begin
    res = '0;
    sat = 1'b0;
    if (a.nan) begin
      res = '0;
    end else if (a.sgn) begin
      if (!a.neg) begin
        if (a.big || rnd > S_MAX_W) begin res = S_MAX; sat = 1'b1; end
        else res = rnd[INT_W-1:0];
      end else begin
        if (a.big || rnd > S_MIN_W) begin res = S_MIN; sat = 1'b1; end
        else res = '0 - rnd[INT_W-1:0];
      end
    end else begin
      if (!a.neg) begin
        if (a.big || rnd[INT_W]) begin res = U_MAX; sat = 1'b1; end
        else res = rnd[INT_W-1:0];
      end else begin
        res = '0;
        sat = a.big || (rnd != '0);
      end
    end
    flags         = '0;
    flags[FL_INV] = a.nan | a.inf;
    flags[FL_SAT] = sat;
    flags[FL_INX] = lost & !sat & !a.nan;
  end
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INT_W-1:0]     in_bits,
  input  logic                 in_signed,
  input  logic                 in_use_cfg,
  input  logic [1:0]           cfg_rmode,
  input  logic                 cfg_ftz,
  input  logic                 status_clr,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [INT_W-1:0]     out_int,
  output logic [FLG_W-1:0]     out_flags,
  output logic [FLG_W-1:0]     status
);
  logic             adv;
  aligned_t         a_n, s1;
  logic             s1_valid;
  logic [INT_W-1:0] r_res;
  logic [FLG_W-1:0] r_flags;
  logic [FLG_W-1:0] status_n;
  logic             o_neg, o_sgn;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  f2i_align u_align (
    .op  (in_bits),
    .ftz (cfg_ftz),
    .neg (a_n.neg),
    .mag (a_n.mag),
    .grd (a_n.grd),
    .stk (a_n.stk),
    .big (a_n.big),
    .nan (a_n.nan),
    .inf (a_n.inf)
  );
  assign a_n.sgn = in_signed;
  assign a_n.rm  = in_use_cfg ? rmode_e'(cfg_rmode) : RM_ZERO;

  f2i_round u_round (
    .a     (s1),
    .res   (r_res),
    .flags (r_flags)
  );

  assign status_n = (status_clr ? '0 : status)
                  | ((adv && s1_valid) ? r_flags : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
      status    <= '0;
    end else begin
      if (adv) begin
        s1_valid  <= in_valid;
        out_valid <= s1_valid;
      end
      status <= status_n;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_valid) s1 <= a_n;
    if (adv && s1_valid) begin
      out_int   <= r_res;
      out_flags <= r_flags;
      o_neg     <= s1.neg;
      o_sgn     <= s1.sgn;
    end
  end

  AST_SAT_NOT_INEXACT: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_SAT] |-> !out_flags[FL_INX]); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_int) && $stable(out_flags)); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
    !status_clr |=> (status & $past(status)) == $past(status)); // R8
  AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_valid && !o_sgn && o_neg |-> out_int == '0); // R5
  AST_SGN_POS_SAT: assert property (@(posedge clk) disable iff (rst)
    out_valid && o_sgn && !o_neg && out_flags[FL_SAT] |-> out_int == {1'b0, {(INT_W-1){1'b1}}}); // R4
endmodule

// File: tb/sim_f2i_conv.sv
`timescale 1ns/1ps
module sim_f2i_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_signed = 1'b0, in_use_cfg = 1'b0;
  logic [31:0] in_bits = '0;
  logic [1:0]  cfg_rmode = 2'b00;
  logic        cfg_ftz = 1'b0, status_clr = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [31:0] out_int;
  logic [2:0]  out_flags, status;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  f2i_conv u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .in_signed(in_signed), .in_use_cfg(in_use_cfg),
    .cfg_rmode(cfg_rmode), .cfg_ftz(cfg_ftz), .status_clr(status_clr),
    .out_ready(out_ready), .out_valid(out_valid), .out_int(out_int),
    .out_flags(out_flags), .status(status)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // exact integer model; flags {inexact, saturated, invalid}
  function automatic void model(input logic [31:0] b, input logic sg, input logic [1:0] rm,
                                input logic ftz, output logic [31:0] r, output logic [2:0] f);
    int ef = int'(b[30:23]);
    longint fr = longint'(b[22:0]);
    bit neg = b[31];
    longint m, q, rem, half, v;
    int e, k, cmp;
    bit nz, up, sat;
    r = '0; f = '0;
    if (ef == 255) begin
      if (fr != 0) begin f = 3'b001; return; end
      f = 3'b011;
      if (sg) r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else    r = neg ? 32'h0 : 32'hFFFF_FFFF;
      return;
    end
    if (ef == 0) begin
      if (fr == 0 || ftz) return;
      m = fr; e = -126;
    end else begin
      m = fr + (longint'(1) << 23); e = ef - 127;
    end
    if (e >= 23) begin
      q = (e > 40) ? (longint'(1) << 50) : (m << (e - 23));
      nz = 0; cmp = -1;
    end else begin
      k = 23 - e;
      if (k > 24) begin q = 0; nz = (m != 0); cmp = -1; end
      else begin
        q = m >> k;
        rem = m - (q << k);
        half = longint'(1) << (k - 1);
        cmp = (rem > half) ? 1 : (rem == half) ? 0 : -1;
        nz = (rem != 0);
      end
    end
    case (rm)
      2'b00:   up = (cmp > 0) || (cmp == 0 && q[0]);
      2'b01:   up = nz && !neg;
      2'b10:   up = nz && neg;
      default: up = 0;
    endcase
    q = q + longint'(up);
    v = neg ? -q : q;
    sat = 0;
    if (sg) begin
      if (v > 64'sd2147483647)       begin r = 32'h7FFF_FFFF; sat = 1; end
      else if (v < -64'sd2147483648) begin r = 32'h8000_0000; sat = 1; end
      else r = v[31:0];
    end else begin
      if (v < 0)                      begin r = 32'h0; sat = 1; end
      else if (v > 64'sd4294967295)   begin r = 32'hFFFF_FFFF; sat = 1; end
      else r = v[31:0];
    end
    f = {nz && !sat, sat, 1'b0};
  endfunction

  task automatic run_op(input logic [31:0] b, input logic sg, input logic uc,
                        input logic [1:0] rm, input logic ftz, input string tag);
    logic [31:0] er;
    logic [2:0]  efl;
    model(b, sg, uc ? rm : 2'b11, ftz, er, efl);
    @(negedge clk);
    in_bits = b; in_signed = sg; in_use_cfg = uc; cfg_rmode = rm; cfg_ftz = ftz; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    if (efl[1]) tag = sg ? {tag, "/R4"} : {tag, "/R5"};
    check(out_valid && out_int == er && out_flags == efl, tag,
          {out_valid, out_int, out_flags}, {1'b1, er, efl});
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog timeout");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  localparam logic [22:0] PATS [8] = '{23'h000000, 23'h400000, 23'h7FFFFF, 23'h000001,
                                       23'h200000, 23'h600000, 23'h555555, 23'h0AAAAA};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(!out_valid && status == 3'b000 && in_ready, "R10 reset",
          {33'b0, out_valid, status[1:0]}, {33'b0, 1'b0, 2'b00});

    // sweep R1/R2/R4/R5/R7
    for (int ef = 100; ef <= 167; ef++)
      for (int p = 0; p < 8; p++)
        for (int s = 0; s < 2; s++)
          for (int sg = 0; sg < 2; sg++)
            for (int md = 0; md < 5; md++)
              run_op({s[0], ef[7:0], PATS[p]}, sg[0], md != 0,
                     (md == 0) ? 2'b00 : 2'(md - 1), 1'b0, (md == 0) ? "R1" : "R2");

    // R2 ties to even
    run_op(32'h4020_0000, 1'b1, 1'b1, 2'b00, 1'b0, "R2 2.5->2");
    run_op(32'h4060_0000, 1'b1, 1'b1, 2'b00, 1'b0, "R2 3.5->4");
    // R1 forced truncation ignores up-rounding
    run_op(32'hBFF0_0000, 1'b1, 1'b0, 2'b10, 1'b0, "R1 -1.875");
    // R3 flush-to-zero
    run_op(32'h0000_0001, 1'b1, 1'b1, 2'b01, 1'b0, "R3 denorm kept");
    run_op(32'h0000_0001, 1'b1, 1'b1, 2'b01, 1'b1, "R3 denorm flushed");
    run_op(32'h8040_0000, 1'b1, 1'b1, 2'b10, 1'b1, "R3 neg denorm flushed");
    // R4 boundaries
    run_op(32'hCF00_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R4 exact min");
    run_op(32'h4F00_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R4 2^31");
    // R5 unsigned
    run_op(32'hBF40_0000, 1'b0, 1'b0, 2'b00, 1'b0, "R5 -0.75 rz");
    run_op(32'hBF40_0000, 1'b0, 1'b1, 2'b10, 1'b0, "R5 R7 -0.75 down");
    run_op(32'h8000_0000, 1'b0, 1'b0, 2'b00, 1'b0, "R5 -0");
    run_op(32'h4F80_0000, 1'b0, 1'b0, 2'b00, 1'b0, "R5 2^32");
    // R6 specials
    run_op(32'h7FC0_0000, 1'b1, 1'b1, 2'b01, 1'b0, "R6 nan");
    run_op(32'hFF80_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R6 -inf");
    run_op(32'h7F80_0000, 1'b0, 1'b0, 2'b00, 1'b0, "R6 +inf uns");
    // R7 inexact
    run_op(32'h3FC0_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R7 1.5");

    // R8 sticky status
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    check(status == 3'b000, "R8 cleared", {33'b0, status}, 36'b0);
    run_op(32'h3FC0_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R8 op1");
    run_op(32'h4040_0000, 1'b1, 1'b0, 2'b00, 1'b0, "R8 op2");
    check(status == 3'b100, "R8 sticky held", {33'b0, status}, {33'b0, 3'b100});
    // clear and new invalid flag in the same cycle: new flag kept
    @(negedge clk);
    in_bits = 32'h7FC0_0000; in_signed = 1'b1; in_use_cfg = 1'b0; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0; status_clr = 1'b1;
    @(posedge clk);
    @(negedge clk); status_clr = 1'b0;
    check(status == 3'b001, "R8 clear vs set", {33'b0, status}, {33'b0, 3'b001});

    // R9 backpressure
    @(negedge clk);
    out_ready = 1'b0; in_signed = 1'b1; in_use_cfg = 1'b0;
    in_bits = 32'h4040_0000; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); in_bits = 32'h40A0_0000;
    @(posedge clk);
    @(negedge clk); in_valid = 1'b0;
    check(out_valid && out_int == 32'd3, "R9 latency", {3'b0, out_valid, out_int}, {3'b0, 1'b1, 32'd3});
    repeat (3) @(negedge clk);
    check(!in_ready && out_valid && out_int == 32'd3, "R9 hold",
          {2'b0, in_ready, out_valid, out_int}, {2'b0, 1'b0, 1'b1, 32'd3});
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid && out_int == 32'd5, "R9 drain", {3'b0, out_valid, out_int}, {3'b0, 1'b1, 32'd5});
    @(negedge clk);
    check(!out_valid && in_ready, "R9 empty", {34'b0, out_valid, in_ready}, {34'b0, 2'b01});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule